// File: doc/BRIEF.md
# Handshaked Byte-Serial Command Link Master

This block is the host end of a byte-wide serial link to a power-management microcontroller. The host writes payload bytes into a small command buffer. It then hands over an opcode and a payload count through a valid/ready handshake. The block looks the opcode up in a 256-entry length table. The table says how many bytes go out and how many reply bytes come back. Either count may be marked variable, in which case the count travels on the wire as a length byte. The block then moves every byte through an external shift stage. Each byte is paced by an active-low request output and an active-low acknowledge input.

The microcontroller can ask for service on a separate attention line. A rising edge there is latched as pending. The next time the block is idle, it sends an interrupt-acknowledge opcode and reads back a variable-length status packet into its own buffer. This happens before any waiting host command is accepted. Every transaction ends with a one-cycle done pulse. The pulse carries the received byte count, an error flag, and a marker that says whether the transaction was an interrupt packet. The shift timing at bit level sits outside the block. It is seen only as a per-byte completion strobe.

Top module: `cmd_link_master`

## Requirements
- R1: Out of reset, treq_no is high, cmd_ready_o is high, and neither sh_load_o nor done_o is asserted.
- R2: Every byte starts with a one-cycle sh_load_o while treq_no is low. treq_no goes high only after sh_done_i has been seen. No further byte is loaded until tack_ni has returned high.
- R3: A command goes out in this order: the opcode, then a length byte equal to the payload count (only when the send count is variable), then the payload bytes from buffer address 0 upward. All of these bytes carry sh_dir_out_o = 1.
- R4: A command is rejected if its send count is fixed and cmd_len_i differs from it, or if cmd_len_i exceeds MAX_BYTES. A rejected command produces done_o with err_o = 1 and count 0, and no byte is loaded.
- R5: When the reply count is zero, done_o (count 0, no error) follows the acknowledge of the last sent byte, and no input byte is started.
- R6: When the reply count is a fixed N, N bytes are received with sh_dir_out_o = 0. They are stored at reply-buffer addresses 0..N-1, and done_o reports count N.
- R7: When the reply count is variable, the first received byte is the length L, followed by L data bytes. L = 0 ends the transaction at once with count 0.
- R8: A received length above MAX_BYTES ends the transaction with err_o = 1 and count 0, and no further bytes are received. A length of exactly MAX_BYTES is accepted.
- R9: A rising edge on attn_i makes the block, once idle, send IRQ_ACK_OP (default 8'h78) with no length byte. It then reads a variable-length packet into the interrupt buffer. The result is signalled by done_o with done_irq_o = 1, and irq_len_o takes the packet length.
- R10: A pending attention is served before any command waiting on cmd_valid_i. cmd_ready_o stays low while the attention is pending.
- R11: If tack_ni does not return high within ACK_TIMEOUT cycles after treq_no rises, the transaction is abandoned with done_o and err_o = 1, and the block returns to idle.
- R12: Each table entry holds {send, reply}, and 8'hFF means variable. The default table is: 0x10 = {1,0}, 0x18 = {0,1}, 0x21 = {0,0}, 0x22 = {2,0}, 0x28 = {0,var}, 0x38 = {0,4}. Any other opcode with bit 3 clear is {var,0}, and any other opcode with bit 3 set is {var,var}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Host command request |
| cmd_ready_o | output | 1 | Command accepted when high together with valid |
| cmd_op_i | input | 8 | Command opcode |
| cmd_len_i | input | clog2(MAX_BYTES+1) | Payload byte count |
| pl_we_i | input | 1 | Payload buffer write enable |
| pl_addr_i | input | clog2(MAX_BYTES) | Payload buffer write address |
| pl_data_i | input | 8 | Payload buffer write data |
| attn_i | input | 1 | Attention request from the microcontroller |
| sh_load_o | output | 1 | Load strobe for the shift stage |
| sh_dir_out_o | output | 1 | 1 = shift out, 0 = shift in |
| sh_tx_o | output | 8 | Byte to shift out |
| sh_rx_i | input | 8 | Byte shifted in, valid with sh_done_i |
| sh_done_i | input | 1 | Byte shift complete |
| treq_no | output | 1 | Transfer request, active low |
| tack_ni | input | 1 | Transfer acknowledge, active low |
| done_o | output | 1 | Transaction finished (one cycle) |
| done_irq_o | output | 1 | Finished transaction was an interrupt packet |
| err_o | output | 1 | Finished transaction failed |
| done_cnt_o | output | clog2(MAX_BYTES+1) | Received byte count |
| rsp_addr_i | input | clog2(MAX_BYTES) | Reply buffer read address |
| rsp_data_o | output | 8 | Reply buffer read data |
| irq_addr_i | input | clog2(MAX_BYTES) | Interrupt buffer read address |
| irq_data_o | output | 8 | Interrupt buffer read data |
| irq_len_o | output | clog2(MAX_BYTES+1) | Length of last good interrupt packet |

## Verification
The bench builds the block with ACK_TIMEOUT = 20. This makes an abandoned acknowledge reachable within a few dozen cycles instead of tens of thousands. MAX_BYTES keeps its default of 32, so the bench can run a full 32-byte reply as well as the rejected length of 33 against the real buffer depth. The default table and IRQ_ACK_OP are kept, so fixed and variable send counts and fixed, variable and zero reply counts are all reachable through chosen opcodes.

// File: rtl/cml_pkg.sv
package cml_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_IACK,
    ST_READ,
    ST_READ_IRQ
  } cml_state_e;

  typedef enum logic {
    PH_SHIFT,
    PH_WAIT
  } cml_phase_e;

  localparam logic [7:0] LEN_VAR = 8'hFF;

  // {send, reply}; LEN_VAR = count travels as a length byte
  function automatic logic [15:0] default_len_entry(input logic [7:0] op);
    logic [15:0] e;
    case (op)
      8'h10:   e = {8'd1, 8'd0};
      8'h18:   e = {8'd0, 8'd1};
      8'h21:   e = {8'd0, 8'd0};
      8'h22:   e = {8'd2, 8'd0};
      8'h28:   e = {8'd0, LEN_VAR};
      8'h38:   e = {8'd0, 8'd4};
      default: e = {LEN_VAR, (op[3] ? LEN_VAR : 8'd0)};
    endcase
    return e;
  endfunction

  function automatic logic [4095:0] default_len_rom();
    logic [4095:0] r;
    r = '0;
    for (int i = 0; i < 256; i++) r[i*16 +: 16] = default_len_entry(8'(i));
    return r;
  endfunction

endpackage

// File: rtl/cml_byte_buf.sv
module cml_byte_buf #(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cml_ack_timer.sv
module cml_ack_timer #(
  parameter int unsigned LIMIT = 32000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cmd_link_master.sv
module cmd_link_master #(
  parameter int unsigned    MAX_BYTES   = 32,
  parameter int unsigned    ACK_TIMEOUT = 32000,
  parameter logic [7:0]     IRQ_ACK_OP  = 8'h78,
  parameter logic [4095:0]  LEN_ROM     = cml_pkg::default_len_rom()
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cmd_valid_i,
  output logic                             cmd_ready_o,
  input  logic [7:0]                       cmd_op_i,
  input  logic [$clog2(MAX_BYTES+1)-1:0]   cmd_len_i,
  input  logic                             pl_we_i,
  input  logic [$clog2(MAX_BYTES)-1:0]     pl_addr_i,
  input  logic [7:0]                       pl_data_i,
  input  logic                             attn_i,
  output logic                             sh_load_o,
  output logic                             sh_dir_out_o,
  output logic [7:0]                       sh_tx_o,
  input  logic [7:0]                       sh_rx_i,
  input  logic                             sh_done_i,
  output logic                             treq_no,
  input  logic                             tack_ni,
  output logic                             done_o,
  output logic                             done_irq_o,
  output logic                             err_o,
  output logic [$clog2(MAX_BYTES+1)-1:0]   done_cnt_o,
  input  logic [$clog2(MAX_BYTES)-1:0]     rsp_addr_i,
  output logic [7:0]                       rsp_data_o,
  input  logic [$clog2(MAX_BYTES)-1:0]     irq_addr_i,
  output logic [7:0]                       irq_data_o,
  output logic [$clog2(MAX_BYTES+1)-1:0]   irq_len_o
);
  import cml_pkg::*;

  localparam int unsigned    CW   = $clog2(MAX_BYTES + 1);
  localparam int unsigned    AW   = $clog2(MAX_BYTES);
  localparam logic [CW-1:0]  MAXC = CW'(MAX_BYTES);
  localparam logic [7:0]     MAX8 = 8'(MAX_BYTES);

  cml_state_e st_q, st_d;
  cml_phase_e ph_q, ph_d;
  logic [CW-1:0] idx_q, idx_d, plen_q, plen_d, rlen_q, rlen_d, cnt_q;
  logic [CW-1:0] idx_inc, fin_cnt, irqlen_q;
  logic [7:0]    rcode_q, rcode_d, rx_q, rx_d, tx_q, lbyte;
  logic          lenb_q, lenb_d, rvar_q, rvar_d, dir_q, dir_d;
  logic          treq_q, treq_d, load_q, done_q, err_q, dirq_q;
  logic          attn_q, pend_q, pend_d, attn_edge;
  logic          launch, fin, fin_err, fin_irq, wr_rsp, wr_irq, tmo, bad_cmd;
  logic [15:0]   entry;
  logic [7:0]    scode, cmd_rd;

  assign attn_edge = attn_i & ~attn_q;
  assign entry     = LEN_ROM[{cmd_op_i, 4'b0000} +: 16];
  assign scode     = entry[15:8];
  assign bad_cmd   = (cmd_len_i > MAXC) || (scode != LEN_VAR && 8'(cmd_len_i) != scode);
  assign idx_inc   = idx_q + 1'b1;
  assign cmd_ready_o = (st_q == ST_IDLE) && !pend_q;

  cml_byte_buf #(.AW(AW)) u_cmd_buf (
    .clk_i, .we_i(pl_we_i), .waddr_i(pl_addr_i), .wdata_i(pl_data_i),
    .raddr_i(idx_q[AW-1:0]), .rdata_o(cmd_rd)
  );

  cml_byte_buf #(.AW(AW)) u_rsp_buf (
    .clk_i, .we_i(wr_rsp), .waddr_i(idx_q[AW-1:0]), .wdata_i(rx_q),
    .raddr_i(rsp_addr_i), .rdata_o(rsp_data_o)
  );

  cml_byte_buf #(.AW(AW)) u_irq_buf (
    .clk_i, .we_i(wr_irq), .waddr_i(idx_q[AW-1:0]), .wdata_i(rx_q),
    .raddr_i(irq_addr_i), .rdata_o(irq_data_o)
  );

  cml_ack_timer #(.LIMIT(ACK_TIMEOUT)) u_ack_timer (
    .clk_i, .rst_ni,
    .run_i((st_q != ST_IDLE) && (ph_q == PH_WAIT) && !tack_ni),
    .expire_o(tmo)
  );

  always_comb begin
    st_d = st_q;  ph_d = ph_q;  idx_d = idx_q;  plen_d = plen_q;
    rlen_d = rlen_q;  rcode_d = rcode_q;  lenb_d = lenb_q;  rvar_d = rvar_q;
    dir_d = dir_q;  rx_d = rx_q;  treq_d = treq_q;
    pend_d = pend_q | attn_edge;
    launch = 1'b0;  lbyte = 8'h00;
    fin = 1'b0;  fin_err = 1'b0;  fin_irq = 1'b0;  fin_cnt = '0;
    wr_rsp = 1'b0;  wr_irq = 1'b0;

    if (st_q == ST_IDLE) begin
      if (pend_q) begin
        pend_d = attn_edge;
        st_d = ST_IACK;  dir_d = 1'b1;
        launch = 1'b1;  lbyte = IRQ_ACK_OP;
      end else if (cmd_valid_i) begin
        if (bad_cmd) begin
          fin = 1'b1;  fin_err = 1'b1;
        end else begin
          st_d = ST_SEND;  dir_d = 1'b1;  idx_d = '0;
          plen_d = cmd_len_i;  rcode_d = entry[7:0];
          lenb_d = (scode == LEN_VAR);
          launch = 1'b1;  lbyte = cmd_op_i;
        end
      end
    end else if (ph_q == PH_SHIFT) begin
      if (sh_done_i) begin
        rx_d = sh_rx_i;  treq_d = 1'b1;  ph_d = PH_WAIT;
      end
    end else if (tmo) begin
      fin = 1'b1;  fin_err = 1'b1;
      fin_irq = (st_q == ST_IACK) || (st_q == ST_READ_IRQ);
      st_d = ST_IDLE;  ph_d = PH_SHIFT;
    end else if (tack_ni) begin
      unique case (st_q)
        ST_SEND: begin
          if (lenb_q) begin
            lenb_d = 1'b0;  launch = 1'b1;  lbyte = 8'(plen_q);
          end else if (idx_q < plen_q) begin
            launch = 1'b1;  lbyte = cmd_rd;  idx_d = idx_inc;
          end else if (rcode_q == 8'd0) begin
            fin = 1'b1;  st_d = ST_IDLE;
          end else begin
            st_d = ST_READ;  idx_d = '0;  dir_d = 1'b0;
            rvar_d = (rcode_q == LEN_VAR);
            rlen_d = rcode_q[CW-1:0];
            launch = 1'b1;
          end
        end
        ST_IACK: begin
          st_d = ST_READ_IRQ;  idx_d = '0;  dir_d = 1'b0;
          rvar_d = 1'b1;  launch = 1'b1;
        end
        default: begin // ST_READ, ST_READ_IRQ
          fin_irq = (st_q == ST_READ_IRQ);
          if (rvar_q) begin
            if (rx_q > MAX8) begin
              fin = 1'b1;  fin_err = 1'b1;  st_d = ST_IDLE;
            end else if (rx_q == 8'd0) begin
              fin = 1'b1;  st_d = ST_IDLE;
            end else begin
              rvar_d = 1'b0;  rlen_d = rx_q[CW-1:0];  launch = 1'b1;
            end
          end else begin
            wr_rsp = (st_q == ST_READ);
            wr_irq = (st_q == ST_READ_IRQ);
            idx_d = idx_inc;
            if (idx_inc < rlen_q) launch = 1'b1;
            else begin
              fin = 1'b1;  fin_cnt = idx_inc;  st_d = ST_IDLE;
            end
          end
        end
      endcase
    end

    if (launch) begin
      ph_d = PH_SHIFT;  treq_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  ph_q <= PH_SHIFT;
      idx_q <= '0;  plen_q <= '0;  rlen_q <= '0;  rcode_q <= '0;
      lenb_q <= 1'b0;  rvar_q <= 1'b0;  dir_q <= 1'b1;  rx_q <= '0;
      treq_q <= 1'b1;  load_q <= 1'b0;  tx_q <= '0;
      attn_q <= 1'b0;  pend_q <= 1'b0;
      done_q <= 1'b0;  err_q <= 1'b0;  dirq_q <= 1'b0;
      cnt_q <= '0;  irqlen_q <= '0;
    end else begin
      st_q <= st_d;  ph_q <= ph_d;
      idx_q <= idx_d;  plen_q <= plen_d;  rlen_q <= rlen_d;  rcode_q <= rcode_d;
      lenb_q <= lenb_d;  rvar_q <= rvar_d;  dir_q <= dir_d;  rx_q <= rx_d;
      treq_q <= treq_d;  load_q <= launch;
      if (launch) tx_q <= lbyte;
      attn_q <= attn_i;  pend_q <= pend_d;
      done_q <= fin;  err_q <= fin & fin_err;  dirq_q <= fin & fin_irq;
      if (fin) cnt_q <= fin_cnt;
      if (fin && fin_irq && !fin_err) irqlen_q <= fin_cnt;
    end
  end

  assign sh_load_o    = load_q;
  assign sh_dir_out_o = dir_q;
  assign sh_tx_o      = tx_q;
  assign treq_no      = treq_q;
  assign done_o       = done_q;
  assign done_irq_o   = dirq_q;
  assign err_o        = err_q;
  assign done_cnt_o   = cnt_q;
  assign irq_len_o    = irqlen_q;

  // R2
  load_low_treq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_load_o |-> !treq_no);

  // R2
  treq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(treq_no) |-> $past(sh_done_i));

  // R2
  ack_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_load_o && $past(st_q != ST_IDLE)) |-> $past(tack_ni));

  // R9
  attn_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && pend_q) |=> (sh_load_o && sh_tx_o == IRQ_ACK_OP));

  // R4
  one_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sh_load_o, done_o}));

  // R8
  cnt_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (done_cnt_o <= MAXC));

  // R11
  tmo_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo |=> (done_o && err_o));
endmodule

// File: tb/cmd_link_master_tb.sv
`timescale 1ns/1ps
module cmd_link_master_tb;
  localparam int unsigned MB = 32;
  localparam int unsigned CW = $clog2(MB + 1);
  localparam int unsigned AW = $clog2(MB);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [7:0] cmd_op = '0;
  logic [CW-1:0] cmd_len = '0;
  logic pl_we = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic attn = 1'b0;
  logic sh_load, sh_dir_out, sh_done = 1'b0, treq_n, tack_n = 1'b1;
  logic [7:0] sh_tx, sh_rx = '0;
  logic done, done_irq, err;
  logic [CW-1:0] done_cnt, irq_len;
  logic [AW-1:0] rsp_addr = '0, irq_addr = '0;
  logic [7:0] rsp_data, irq_data;

  int total = 0, bad = 0, ndone = 0, nload = 0;
  bit stuck = 1'b0;
  logic [7:0] exp_tx[$];
  logic [7:0] rx_src[$];
  logic [7:0] exp_done[$];

  always #2 clk = ~clk;

  cmd_link_master #(.MAX_BYTES(MB), .ACK_TIMEOUT(20)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op), .cmd_len_i(cmd_len),
    .pl_we_i(pl_we), .pl_addr_i(pl_addr), .pl_data_i(pl_data),
    .attn_i(attn),
    .sh_load_o(sh_load), .sh_dir_out_o(sh_dir_out), .sh_tx_o(sh_tx), .sh_rx_i(sh_rx),
    .sh_done_i(sh_done), .treq_no(treq_n), .tack_ni(tack_n),
    .done_o(done), .done_irq_o(done_irq), .err_o(err), .done_cnt_o(done_cnt),
    .rsp_addr_i(rsp_addr), .rsp_data_o(rsp_data),
    .irq_addr_i(irq_addr), .irq_data_o(irq_data), .irq_len_o(irq_len)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // link slave + wire monitor
  initial begin
    logic [7:0] rb, e;
    forever begin
      @(negedge clk);
      if (sh_load) begin
        nload++;
        chk(!treq_n && tack_n, "R2 load with treq low, ack high", {treq_n, tack_n}, 2'b01);
        if (sh_dir_out) begin
          if (exp_tx.size() == 0) chk(1'b0, "R3 unexpected out byte", sh_tx, -1);
          else begin
            e = exp_tx.pop_front();
            chk(sh_tx == e, "R3 out byte", sh_tx, e);
          end
          rb = 8'h00;
        end else rb = (rx_src.size() != 0) ? rx_src.pop_front() : 8'hEE;
        repeat (2) @(negedge clk);
        tack_n = 1'b0; sh_rx = rb; sh_done = 1'b1;
        @(negedge clk);
        sh_done = 1'b0;
        if (stuck) begin
          while (!done) @(negedge clk);
          tack_n = 1'b1; stuck = 1'b0;
        end else begin
          repeat (3) @(negedge clk);
          tack_n = 1'b1;
        end
      end
    end
  end

  // completion monitor
  initial begin
    logic [7:0] e;
    forever begin
      @(negedge clk);
      if (done) begin
        ndone++;
        if (exp_done.size() == 0) chk(1'b0, "R4 unexpected done", {done_irq, err, done_cnt}, -1);
        else begin
          e = exp_done.pop_front();
          chk({done_irq, err, done_cnt} == e, "R6 done irq/err/cnt", {done_irq, err, done_cnt}, e);
        end
      end
    end
  end

  task automatic load_pl(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pl_we = 1'b1; pl_addr = AW'(i); pl_data = base + 8'(i);
    end
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic issue(input logic [7:0] op, input int len);
    @(negedge clk);
    cmd_op = op; cmd_len = CW'(len); cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_dones(input int target);
    while (ndone < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_attn();
    @(negedge clk); attn = 1'b1;
    @(negedge clk); attn = 1'b0;
  endtask

  task automatic chk_rsp(input int a, input logic [7:0] e, input string req);
    rsp_addr = AW'(a); #1;
    chk(rsp_data == e, req, rsp_data, e);
  endtask

  task automatic chk_irq(input int a, input logic [7:0] e, input string req);
    irq_addr = AW'(a); #1;
    chk(irq_data == e, req, irq_data, e);
  endtask

  initial begin
    int nl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(treq_n == 1'b1, "R1 treq idle high", treq_n, 1);
    chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    chk(done == 1'b0 && sh_load == 1'b0, "R1 no done/load", {done, sh_load}, 0);

    // R12 R3 fixed send of two bytes
    load_pl(2, 8'hA0);
    exp_tx.push_back(8'h22); exp_tx.push_back(8'hA0); exp_tx.push_back(8'hA1);
    exp_done.push_back(8'h00);
    issue(8'h22, 2); wait_dones(1);

    // R3 variable send: length byte inserted
    load_pl(3, 8'hB0);
    exp_tx.push_back(8'h05); exp_tx.push_back(8'h03);
    exp_tx.push_back(8'hB0); exp_tx.push_back(8'hB1); exp_tx.push_back(8'hB2);
    exp_done.push_back(8'h00);
    issue(8'h05, 3); wait_dones(2);

    // R4 rejects: count mismatch and oversize
    nl = nload;
    exp_done.push_back({2'b01, 6'd0});
    issue(8'h22, 1); wait_dones(3);
    exp_done.push_back({2'b01, 6'd0});
    issue(8'h05, 33); wait_dones(4);
    chk(nload == nl, "R4 no bus activity on reject", nload - nl, 0);

    // R6 fixed reply of four
    exp_tx.push_back(8'h38);
    rx_src.push_back(8'h11); rx_src.push_back(8'h22); rx_src.push_back(8'h33); rx_src.push_back(8'h44);
    exp_done.push_back({2'b00, 6'd4});
    issue(8'h38, 0); wait_dones(5);
    chk_rsp(0, 8'h11, "R6 reply[0]");
    chk_rsp(3, 8'h44, "R6 reply[3]");

    // R7 variable reply
    exp_tx.push_back(8'h28);
    rx_src.push_back(8'h03); rx_src.push_back(8'hC0); rx_src.push_back(8'hC1); rx_src.push_back(8'hC2);
    exp_done.push_back({2'b00, 6'd3});
    issue(8'h28, 0); wait_dones(6);
    chk_rsp(2, 8'hC2, "R7 reply[2]");

    // R7 zero-length reply
    nl = nload;
    exp_tx.push_back(8'h28); rx_src.push_back(8'h00);
    exp_done.push_back(8'h00);
    issue(8'h28, 0); wait_dones(7);
    chk(nload - nl == 2, "R7 zero length stops", nload - nl, 2);

    // R8 oversize length
    nl = nload;
    exp_tx.push_back(8'h28); rx_src.push_back(8'd33);
    exp_done.push_back({2'b01, 6'd0});
    issue(8'h28, 0); wait_dones(8);
    chk(nload - nl == 2, "R8 no bytes after bad length", nload - nl, 2);

    // R8 exactly MAX
    exp_tx.push_back(8'h28); rx_src.push_back(8'd32);
    for (int i = 0; i < 32; i++) rx_src.push_back(8'hD0 + 8'(i));
    exp_done.push_back({2'b00, 6'd32});
    issue(8'h28, 0); wait_dones(9);
    chk_rsp(31, 8'hEF, "R8 reply[31]");

    // R5 no reply
    nl = nload;
    exp_tx.push_back(8'h21); exp_done.push_back(8'h00);
    issue(8'h21, 0); wait_dones(10);
    chk(nload - nl == 1, "R5 no input byte", nload - nl, 1);

    // R9 attention packet
    exp_tx.push_back(8'h78);
    rx_src.push_back(8'h02); rx_src.push_back(8'hE0); rx_src.push_back(8'hE1);
    exp_done.push_back({2'b10, 6'd2});
    pulse_attn(); wait_dones(11);
    chk(irq_len == 6'd2, "R9 irq length", irq_len, 2);
    chk_irq(0, 8'hE0, "R9 irq[0]");
    chk_irq(1, 8'hE1, "R9 irq[1]");

    // R10 attention beats a waiting command
    load_pl(2, 8'h60);
    exp_tx.push_back(8'h38); exp_tx.push_back(8'h78);
    exp_tx.push_back(8'h22); exp_tx.push_back(8'h60); exp_tx.push_back(8'h61);
    rx_src.push_back(8'h51); rx_src.push_back(8'h52); rx_src.push_back(8'h53); rx_src.push_back(8'h54);
    rx_src.push_back(8'h01); rx_src.push_back(8'h70);
    exp_done.push_back({2'b00, 6'd4}); exp_done.push_back({2'b10, 6'd1}); exp_done.push_back(8'h00);
    issue(8'h38, 0);
    pulse_attn();
    fork
      issue(8'h22, 2);
      begin
        while (!done) @(negedge clk);
        chk(cmd_ready == 1'b0, "R10 ready low while attention pending", cmd_ready, 0);
      end
    join
    wait_dones(14);
    chk_irq(0, 8'h70, "R10 irq served first");

    // R11 acknowledge timeout, then recovery
    stuck = 1'b1;
    exp_tx.push_back(8'h21); exp_done.push_back({2'b01, 6'd0});
    issue(8'h21, 0); wait_dones(15);
    exp_tx.push_back(8'h21); exp_done.push_back(8'h00);
    issue(8'h21, 0); wait_dones(16);

    // R7 R9 empty interrupt packet
    exp_tx.push_back(8'h78); rx_src.push_back(8'h00);
    exp_done.push_back({2'b10, 6'd0});
    pulse_attn(); wait_dones(17);
    chk(irq_len == 6'd0, "R9 irq length zero", irq_len, 0);

    repeat (5) @(negedge clk);
    chk(exp_tx.size() == 0, "R3 all wire bytes seen", exp_tx.size(), 0);
    chk(exp_done.size() == 0, "R6 all completions seen", exp_done.size(), 0);
    chk(rx_src.size() == 0, "R6 all input bytes used", rx_src.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", ndone, 17);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule